// File: doc/BRIEF.md
# Programmable AND-OR Logic Array

A two-level sum-of-products engine whose contents are written at run time. The block has `N_IN` inputs, `N_TERM` product terms and `N_OUT` outputs. Each product term is a stored row. For every input, the row holds a two-bit literal code that places the input in the term true, complemented, or not at all. The row also holds a mask that chooses which outputs the term feeds.

The AND plane forms every product term from the buffered inputs. The OR plane then sums the terms selected for each output. Each output leaves the block either directly from its OR sum or through a flip-flop, chosen by a per-output select bit. The registered path lets feedback logic outside the block build state machines.

Rows are written one per clock through a term index and a strobe. A synchronous reset clears every row, so that no term reaches any output. Several arrays driven from the same inputs add outputs without changing the input or term counts.

Top module: `pla_array`

## Requirements
- R1: Every output equals the OR of all product terms whose mask bit for that output is set. Each product term is the AND of its literals over the current `din`.
- R2: The literal code for input i sits at `cfg_lits[2i+1:2i]`. 2'b01 uses `din[i]` true, 2'b10 uses it complemented, 2'b00 leaves it out, and 2'b11 forces the whole term to 0.
- R3: A product term whose literal codes are all 2'b00 evaluates to 1.
- R4: An output with no mask bit set in any row is 0.
- R5: When `cfg_we` is high at a rising edge and `cfg_term` < `N_TERM`, row `cfg_term` takes `cfg_lits` and `cfg_mask` (mask bit o connects output o). The new row acts from that edge onward.
- R6: A write with `cfg_term` >= `N_TERM` changes no row and no output.
- R7: Synchronous reset (`rst` high at a rising edge) clears every row and every output flop. After reset all outputs read 0 for any `din`.
- R8: With `out_reg_sel[o]`=1, `dout[o]` shows the OR sum sampled at the last rising edge.
- R9: With `out_reg_sel[o]`=0, `dout[o]` follows the OR sum in the same cycle.
- R10: Loaded with a nine-term BCD to Excess-3 table, the array gives `dout` = `din` + 3 for `din` 0 to 9. Bit 0 uses the single term "not din[0]". Bit 3 uses "din[3]", "din[2] and din[0]" and "din[2] and din[1]".

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Row write strobe |
| cfg_term | input | TW = max(1, clog2(N_TERM)) | Index of the row to write |
| cfg_lits | input | 2*N_IN | Literal codes, two bits per input |
| cfg_mask | input | N_OUT | OR-plane connection mask |
| out_reg_sel | input | N_OUT | Per output: 1 registered, 0 combinational |
| din | input | N_IN | Array inputs |
| dout | output | N_OUT | Array outputs |

## Verification
The bench builds the block with its defaults: 4 inputs, 9 terms, 4 outputs, and every output able to register. Nine terms is exactly enough for the Excess-3 table, and a 4-bit index that runs past 8 makes indices 9 to 15 reachable for the ignored-write case. With four inputs, every literal code and every input value can be combined in random rows. Every output can switch between its direct and registered paths at any cycle, which exposes timing slips between the two.

// File: rtl/pla_pkg.sv
package pla_pkg;
   typedef enum logic [1:0] {
      LIT_DROP = 2'b00,
      LIT_POS  = 2'b01,
      LIT_NEG  = 2'b10,
      LIT_KILL = 2'b11
   } lit_e;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/pla_row_store.sv
module pla_row_store #(
   parameter int N_IN   = 4,
   parameter int N_TERM = 9,
   parameter int N_OUT  = 4,
   localparam int TW    = pla_pkg::idx_width(N_TERM),
   localparam int LW    = 2 * N_IN
) (
   input  logic                              clk,
   input  logic                              rst,
   input  logic                              wr_en,
   input  logic [TW-1:0]                     wr_idx,
   input  logic [LW-1:0]                     wr_lits,
   input  logic [N_OUT-1:0]                  wr_mask,
   output logic [N_TERM-1:0][LW-1:0]         lits_q,
   output logic [N_TERM-1:0][N_OUT-1:0]      mask_q
);
   localparam logic [TW:0] TERM_LIM = (TW+1)'(N_TERM);

   logic idx_ok;
   assign idx_ok = ({1'b0, wr_idx} < TERM_LIM);

   for (genvar t = 0; t < N_TERM; t++) begin : g_row
      logic hit;
      assign hit = wr_en && (wr_idx == TW'(t));
      always_ff @(posedge clk) begin
         if (rst) begin
            lits_q[t] <= '0;
            mask_q[t] <= '0;
         end else if (hit) begin
            lits_q[t] <= wr_lits;
            mask_q[t] <= wr_mask;
         end
      end
   end

   // R5: an in-range write lands in the addressed row
   p_row_load_r5: assert property (@(posedge clk) disable iff (rst)
      (wr_en && idx_ok) |=> (lits_q[$past(wr_idx)] == $past(wr_lits))
                            && (mask_q[$past(wr_idx)] == $past(wr_mask)));

   // R6: an out-of-range write touches nothing
   p_bad_idx_ignored_r6: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !idx_ok) |=> ($stable(lits_q) && $stable(mask_q)));

   // R7: reset leaves no connection in the OR plane
   p_reset_clears_r7: assert property (@(posedge clk)
      rst |=> (mask_q == '0));
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
   parameter int N_IN   = 4,
   parameter int N_TERM = 9,
   localparam int LW    = 2 * N_IN
) (
   input  logic [N_IN-1:0]           din,
   input  logic [N_TERM-1:0][LW-1:0] lits_q,
   output logic [N_TERM-1:0]         term_hit
);
   import pla_pkg::*;

   for (genvar t = 0; t < N_TERM; t++) begin : g_term
      logic [N_IN-1:0] lit_ok;
      for (genvar i = 0; i < N_IN; i++) begin : g_lit
         always_comb begin
            unique case (lit_e'(lits_q[t][2*i +: 2]))
               LIT_DROP: lit_ok[i] = 1'b1;
               LIT_POS:  lit_ok[i] = din[i];
               LIT_NEG:  lit_ok[i] = ~din[i];
               default:  lit_ok[i] = 1'b0;
            endcase
         end
      end
      assign term_hit[t] = &lit_ok;
   end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
   parameter int N_TERM = 9,
   parameter int N_OUT  = 4
) (
   input  logic [N_TERM-1:0]            term_hit,
   input  logic [N_TERM-1:0][N_OUT-1:0] mask_q,
   output logic [N_OUT-1:0]             sum
);
   for (genvar o = 0; o < N_OUT; o++) begin : g_sum
      logic [N_TERM-1:0] feed;
      for (genvar t = 0; t < N_TERM; t++) begin : g_feed
         assign feed[t] = term_hit[t] & mask_q[t][o];
      end
      assign sum[o] = |feed;
   end
endmodule

// File: rtl/pla_out_stage.sv
module pla_out_stage #(
   parameter int                 N_OUT       = 4,
   parameter logic [N_OUT-1:0]   REG_CAPABLE = '1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [N_OUT-1:0] sum,
   input  logic [N_OUT-1:0] sel,
   output logic [N_OUT-1:0] dout
);
   for (genvar o = 0; o < N_OUT; o++) begin : g_out
      if (REG_CAPABLE[o]) begin : g_flop
         logic q;
         always_ff @(posedge clk) begin
            if (rst) q <= 1'b0;
            else     q <= sum[o];
         end
         assign dout[o] = sel[o] ? q : sum[o];

         // R8: the flop carries the previous edge's sum
         p_reg_tracks_r8: assert property (@(posedge clk) disable iff (rst)
            !rst |=> (q == $past(sum[o])));
         // R7: reset empties the output flop
         p_reg_clear_r7: assert property (@(posedge clk)
            rst |=> (q == 1'b0));
      end else begin : g_wire
         logic unused_sel;
         assign unused_sel = sel[o];
         assign dout[o] = sum[o];
      end
   end
endmodule

// File: rtl/pla_array.sv
module pla_array #(
   parameter int               N_IN        = 4,
   parameter int               N_TERM      = 9,
   parameter int               N_OUT       = 4,
   parameter logic [N_OUT-1:0] REG_CAPABLE = '1,
   localparam int              TW          = pla_pkg::idx_width(N_TERM),
   localparam int              LW          = 2 * N_IN
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_we,
   input  logic [TW-1:0]     cfg_term,
   input  logic [LW-1:0]     cfg_lits,
   input  logic [N_OUT-1:0]  cfg_mask,
   input  logic [N_OUT-1:0]  out_reg_sel,
   input  logic [N_IN-1:0]   din,
   output logic [N_OUT-1:0]  dout
);
   if (N_IN < 1)   begin : g_bad_in   $error("pla_array: N_IN must be at least 1");   end
   if (N_TERM < 1) begin : g_bad_term $error("pla_array: N_TERM must be at least 1"); end
   if (N_OUT < 1)  begin : g_bad_out  $error("pla_array: N_OUT must be at least 1");  end

   logic [N_TERM-1:0][LW-1:0]    lits_q;
   logic [N_TERM-1:0][N_OUT-1:0] mask_q;
   logic [N_TERM-1:0]            term_hit;
   logic [N_OUT-1:0]             sum;

   pla_row_store #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) u_rows (
      .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_idx(cfg_term),
      .wr_lits(cfg_lits), .wr_mask(cfg_mask),
      .lits_q(lits_q), .mask_q(mask_q));

   pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
      .din(din), .lits_q(lits_q), .term_hit(term_hit));

   pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
      .term_hit(term_hit), .mask_q(mask_q), .sum(sum));

   pla_out_stage #(.N_OUT(N_OUT), .REG_CAPABLE(REG_CAPABLE)) u_out (
      .clk(clk), .rst(rst), .sum(sum), .sel(out_reg_sel), .dout(dout));
endmodule

// File: tb/test_pla_array.sv
`timescale 1ns/1ps
module test_pla_array;
   localparam int NI = 4;
   localparam int NT = 9;
   localparam int NO = 4;
   localparam int TW = 4;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          cfg_we = 1'b0;
   logic [TW-1:0] cfg_term = '0;
   logic [2*NI-1:0] cfg_lits = '0;
   logic [NO-1:0] cfg_mask = '0;
   logic [NO-1:0] out_reg_sel = '0;
   logic [NI-1:0] din = '0;
   logic [NO-1:0] dout;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   pla_array #(.N_IN(NI), .N_TERM(NT), .N_OUT(NO)) i_pla_array (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_term(cfg_term),
      .cfg_lits(cfg_lits), .cfg_mask(cfg_mask), .out_reg_sel(out_reg_sel),
      .din(din), .dout(dout));

   // behavioural reference
   logic [2*NI-1:0] m_lits [NT];
   logic [NO-1:0]   m_mask [NT];
   logic [NO-1:0]   m_q;

   function automatic logic [NO-1:0] ref_sum(input logic [NI-1:0] x);
      logic [NO-1:0] r = '0;
      for (int o = 0; o < NO; o++) begin
         for (int t = 0; t < NT; t++) begin
            if (m_mask[t][o]) begin
               bit prod = 1'b1;
               for (int i = 0; i < NI; i++) begin
                  int code = int'(m_lits[t][2*i +: 2]);
                  if (code == 1 && !x[i]) prod = 1'b0;
                  if (code == 2 && x[i])  prod = 1'b0;
                  if (code == 3)          prod = 1'b0;
               end
               if (prod) r[o] = 1'b1;
            end
         end
      end
      return r;
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_q <= '0;
         for (int t = 0; t < NT; t++) begin
            m_lits[t] <= '0;
            m_mask[t] <= '0;
         end
      end else begin
         m_q <= ref_sum(din);
         if (cfg_we && int'(cfg_term) < NT) begin
            m_lits[cfg_term] <= cfg_lits;
            m_mask[cfg_term] <= cfg_mask;
         end
      end
   end

   task automatic check(input string tag, input logic [NO-1:0] act, input logic [NO-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: dout=%b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   // one clock: drive at falling edge, compare against the model 3 ns later
   task automatic step(input string tag, input logic [NI-1:0] d, input logic [NO-1:0] sel,
                       input logic we, input logic [TW-1:0] idx,
                       input logic [2*NI-1:0] lits, input logic [NO-1:0] mask);
      @(negedge clk);
      din = d; out_reg_sel = sel; cfg_we = we; cfg_term = idx;
      cfg_lits = lits; cfg_mask = mask;
      #3;
      if (!rst) check(tag, dout, (sel & m_q) | (~sel & ref_sum(d)));
   endtask

   task automatic wr(input string tag, input int idx, input logic [2*NI-1:0] lits, input logic [NO-1:0] mask);
      step(tag, din, out_reg_sel, 1'b1, TW'(idx), lits, mask);
   endtask

   task automatic idle(input string tag, input logic [NI-1:0] d, input logic [NO-1:0] sel);
      step(tag, d, sel, 1'b0, '0, '0, '0);
   endtask

   task automatic do_reset;
      @(negedge clk); rst = 1'b1; cfg_we = 1'b0;
      @(negedge clk);
      @(negedge clk); rst = 1'b0;
   endtask

   function automatic logic [7:0] row(input int c3, input int c2, input int c1, input int c0);
      return {2'(c3), 2'(c2), 2'(c1), 2'(c0)};
   endfunction

   initial begin
      #2_000_000;
      n_bad++; n_chk++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      do_reset();
      // R7: reset state, cleared rows give zero everywhere
      for (int v = 0; v < 16; v++) begin
         idle("R7", NI'(v), '0);
         check("R7 reset-clear", dout, '0);
      end
      idle("R7", 4'h0, '1);
      check("R7 flops clear", dout, '0);

      // R3/R4: an all-absent term feeding output 0 only
      wr("R5", 0, row(0,0,0,0), 4'b0001);
      for (int v = 0; v < 16; v += 5) begin
         idle("R3", NI'(v), '0);
         check("R3 empty term is 1", {1'b0, 1'b0, 1'b0, dout[0]}, 4'b0001);
         check("R4 unconnected outputs 0", {dout[3:1], 1'b0}, 4'b0000);
      end

      // R2: literal codes
      wr("R5", 1, row(0,0,3,0), 4'b0010);
      wr("R5", 2, row(0,1,0,0), 4'b0100);
      wr("R5", 3, row(2,0,0,0), 4'b1000);
      for (int v = 0; v < 16; v++) begin
         logic [NI-1:0] d = NI'(v);
         idle("R2", d, '0);
         check("R2 kill code", {3'b0, dout[1]}, 4'b0000);
         check("R2 true/compl", {dout[3], dout[2], 2'b0}, {~d[3], d[2], 2'b0});
      end

      // R6: out-of-range writes are ignored
      for (int k = NT; k < 16; k++) begin
         wr("R6", k, row(0,0,0,0), 4'b1111);
         idle("R6", 4'h0, '0);
         check("R6 ignored write", dout, 4'b1001);
      end

      // R8/R9: registered versus direct path on output 2 (din[2] true)
      idle("R9", 4'h4, 4'b0000);
      check("R9 direct", dout[2] ? 4'b0100 : 4'b0000, 4'b0100);
      idle("R8", 4'h4, 4'b0100);
      idle("R8", 4'h0, 4'b0100);
      check("R8 holds last edge", dout[2] ? 4'b0100 : 4'b0000, 4'b0100);
      idle("R8", 4'h0, 4'b0100);
      check("R8 follows next edge", dout[2] ? 4'b0100 : 4'b0000, 4'b0000);

      // R10: Excess-3 table
      do_reset();
      wr("R10", 0, row(1,0,0,0), 4'b1000);
      wr("R10", 1, row(0,1,0,1), 4'b1000);
      wr("R10", 2, row(0,1,1,0), 4'b1000);
      wr("R10", 3, row(0,2,1,0), 4'b0100);
      wr("R10", 4, row(0,2,0,1), 4'b0100);
      wr("R10", 5, row(0,1,2,2), 4'b0100);
      wr("R10", 6, row(0,0,2,2), 4'b0010);
      wr("R10", 7, row(0,0,1,1), 4'b0010);
      wr("R10", 8, row(0,0,0,2), 4'b0001);
      for (int v = 0; v < 10; v++) begin
         idle("R10", NI'(v), '0);
         check("R10 excess-3", dout, NO'(v + 3));
      end
      for (int v = 0; v < 10; v++) idle("R10 registered", NI'(v), '1);

      // R1/R5/R8/R9: random rows, inputs and path selects
      for (int n = 0; n < 600; n++) begin
         if (n == 300) begin
            do_reset();
            idle("R7", 4'hF, '0);
            check("R7 mid-run reset", dout, '0);
         end
         step("R1", NI'($urandom), NO'($urandom), 1'($urandom % 3 == 0),
              TW'($urandom), 8'($urandom), NO'($urandom));
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule